// File: doc/BRIEF.md
# Indexed Filter Table Register Bank

This block is the configuration store behind a receive frame filter. It holds a 48-bit station (unicast) address, a control word with a pass-everything flag, and a table of filter entries. Each entry has a 512-bit match value, a 512-bit compare mask and one enable bit. Sixteen general entries and three dedicated entries are built by default.

The table is reached indirectly. The host writes an index and a bank-select bit into the control word. After that, one shared window of sixteen value words, sixteen mask words and one enable word addresses the entry chosen by that pair. The matching engine does not use the bus. It reads every entry's value, mask and enable in parallel from wide export ports, together with the unicast address and the pass-everything flag.

Read responses come from a two-state sequencer. RS_IDLE drives zero on the read data bus. RS_RESP presents the word that was captured on the previous clock. A read request in either state moves the sequencer to RS_RESP. A cycle with no read request moves it to RS_IDLE. When the parameter FILTER_PRESENT is 0, no entry storage is built and every read returns zero.

Top module: `ffc_filter_bank`

## Requirements
- R1: After reset the registers hold these values. The control word reads 0x8000_0000. The enable word reads 1. Value words 0 and 1 of every entry read 0xFFFF_FFFF and 0x0000_FFFF, and all higher value words read 0. The mask words follow the same pattern. Both unicast words read 0.
- R2: The unicast address is split across two words. Offset 0x700 holds bits 31:0. Bits 15:0 of offset 0x704 hold bits 47:32, and bits 31:16 of 0x704 read 0 and ignore writes. The first byte on the wire sits in the lowest byte lane. Writing 0xDDCCBBAA and then 0x0000FFEE exports 0xFFEEDDCCBBAA.
- R3: The control word is at 0x708. Bit 31 is the pass-everything flag and drives `promisc_en`. Bit 8 is the bank select (1 = dedicated). Bits 3:0 are the index. All other bits read 0.
- R4: Value words sit at 0x710 + 4w and mask words at 0x750 + 4w, for w = 0..15. Word w covers entry bytes 4w+3..4w. The physical entry is p = index when the bank select is 0, and p = 16 + index when it is 1. Word w of entry p appears at bits [p*512 + 32w +: 32] of `flt_value` or `flt_mask`.
- R5: Bit 0 of the enable word at 0x70C holds the enable of the selected entry and appears at `flt_enable[p]`. Bits 31:1 read 0.
- R6: With the bank select at 1 and an index above 2, window writes (value, mask, enable) change no entry, and window reads return 0.
- R7: A read of an address outside 0x700..0x78C, or of an address that is not a multiple of 4, returns 0.
- R8: Read data is valid on the clock after the read request. On a clock that follows a cycle with no read request, `bus_rd_data` is 0.
- R9: A write takes effect on the clock edge where it is presented. A read issued on the next cycle returns the new value, and the exports show it from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read request |
| bus_rd_data | output | 32 | Read data, one clock after the request |
| unicast_addr | output | 48 | Station address for the matcher |
| promisc_en | output | 1 | Pass-everything flag |
| flt_value | output | 19*512 | Match values of all entries, entry p at bits p*512 |
| flt_mask | output | 19*512 | Compare masks of all entries |
| flt_enable | output | 19 | Enable bit of each entry |

## Verification
A write becomes visible on the edge that accepts it. The bench therefore checks the exports at the falling edge after the write strobe, and a read of the same word can be issued on the very next cycle. Read data arrives one edge after the request. The bench asserts the request on a falling edge and samples `bus_rd_data` on the next falling edge, so the sample sits after the capture edge. It then holds one idle cycle and checks that the data bus has returned to zero. Expected values come from a bench model of the register map that is updated on every write the bench issues, including the writes that must be ignored.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int WIN_WORDS = 16;
    localparam int IDX_W     = 4;

    localparam logic [ADDR_W-1:0] OFS_UC_LO  = 12'h700;
    localparam logic [ADDR_W-1:0] OFS_UC_HI  = 12'h704;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h708;
    localparam logic [ADDR_W-1:0] OFS_ENA    = 12'h70C;
    localparam logic [ADDR_W-1:0] OFS_VAL    = 12'h710;
    localparam logic [ADDR_W-1:0] OFS_MSK    = 12'h750;
    localparam logic [ADDR_W-1:0] OFS_END    = 12'h790;

    localparam int CTRL_PROM_BIT = 31;
    localparam int CTRL_BANK_BIT = 8;

    typedef enum logic [2:0] {
        RK_NONE, RK_UC_LO, RK_UC_HI, RK_CTRL, RK_ENA, RK_VAL, RK_MSK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [IDX_W-1:0]   word;
    } reg_sel_t;

    typedef enum logic {
        RS_IDLE,
        RS_RESP
    } rd_state_e;
endpackage

// File: rtl/ffc_decode.sv
module ffc_decode
    import ffc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    always_comb begin
        sel.kind = RK_NONE;
        // Window words start at an offset whose bits 5:2 equal 4.
        sel.word = addr[5:2] - 4'd4;
        if (addr[1:0] == 2'b00) begin
            if (addr == OFS_UC_LO)                          sel.kind = RK_UC_LO;
            else if (addr == OFS_UC_HI)                     sel.kind = RK_UC_HI;
            else if (addr == OFS_CTRL)                      sel.kind = RK_CTRL;
            else if (addr == OFS_ENA)                       sel.kind = RK_ENA;
            else if (addr >= OFS_VAL && addr < OFS_MSK)     sel.kind = RK_VAL;
            else if (addr >= OFS_MSK && addr < OFS_END)     sel.kind = RK_MSK;
        end
    end
endmodule

// File: rtl/ffc_entry.sv
module ffc_entry #(
    parameter  int WORDS = 16,
    localparam int WW    = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         wr_data,
    input  logic [WW-1:0]       word,
    input  logic                val_we,
    input  logic                msk_we,
    input  logic                en_we,
    output logic [WORDS*32-1:0] value_o,
    output logic [WORDS*32-1:0] mask_o,
    output logic                en_o
);
    logic [31:0] val_q [WORDS];
    logic [31:0] msk_q [WORDS];
    logic        en_q;

    function automatic logic [31:0] reset_word(input int w);
        if (w == 0)      return 32'hFFFF_FFFF;
        else if (w == 1) return 32'h0000_FFFF;
        else             return 32'h0;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                val_q[w] <= reset_word(w);
                msk_q[w] <= reset_word(w);
            end
            en_q <= 1'b1;
        end else begin
            if (val_we) val_q[word] <= wr_data;
            if (msk_we) msk_q[word] <= wr_data;
            if (en_we)  en_q        <= wr_data[0];
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_flat
        assign value_o[w*32 +: 32] = val_q[w];
        assign mask_o[w*32 +: 32]  = msk_q[w];
    end
    assign en_o = en_q;
endmodule

// File: rtl/ffc_rd_fsm.sv
module ffc_rd_fsm
    import ffc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);
    rd_state_e         state_q, state_d;
    logic [DATA_W-1:0] hold_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: if (rd_en)  state_d = RS_RESP;
            RS_RESP: if (!rd_en) state_d = RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en) hold_q <= rd_word;
        end
    end

    always_comb begin
        unique case (state_q)
            RS_RESP: rd_data = hold_q;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ffc_filter_bank.sv
module ffc_filter_bank
    import ffc_pkg::*;
#(
    parameter  int NUM_GEN        = 16,
    parameter  int NUM_DED        = 3,
    parameter  int FILTER_PRESENT = 1,
    localparam int TOTAL          = NUM_GEN + NUM_DED,
    localparam int EBITS          = WIN_WORDS * DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr_en,
    input  logic [DATA_W-1:0]       bus_wr_data,
    input  logic                    bus_rd_en,
    output logic [DATA_W-1:0]       bus_rd_data,
    output logic [47:0]             unicast_addr,
    output logic                    promisc_en,
    output logic [TOTAL*EBITS-1:0]  flt_value,
    output logic [TOTAL*EBITS-1:0]  flt_mask,
    output logic [TOTAL-1:0]        flt_enable
);
    localparam int PW = $clog2(TOTAL);
    localparam logic [IDX_W:0] GEN_LIM = (IDX_W+1)'(NUM_GEN);
    localparam logic [IDX_W:0] DED_LIM = (IDX_W+1)'(NUM_DED);

    reg_sel_t           dec;
    logic               prom_q, sel_q;
    logic [IDX_W-1:0]   idx_q;
    logic [31:0]        uc_lo_q;
    logic [15:0]        uc_hi_q;
    logic [PW-1:0]      phys;
    logic               legal, win_we;
    logic [TOTAL*EBITS-1:0] val_all, msk_all;
    logic [TOTAL-1:0]   en_all;
    logic [DATA_W-1:0]  mux_word, rd_word;

    ffc_decode u_dec (.addr(bus_addr), .sel(dec));

    assign phys  = sel_q ? (PW'(NUM_GEN) + PW'(idx_q)) : PW'(idx_q);
    assign legal = sel_q ? ({1'b0, idx_q} < DED_LIM) : ({1'b0, idx_q} < GEN_LIM);
    assign win_we = bus_wr_en && legal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prom_q  <= 1'b1;
            sel_q   <= 1'b0;
            idx_q   <= '0;
            uc_lo_q <= '0;
            uc_hi_q <= '0;
        end else if (bus_wr_en) begin
            unique case (dec.kind)
                RK_UC_LO: uc_lo_q <= bus_wr_data;
                RK_UC_HI: uc_hi_q <= bus_wr_data[15:0];
                RK_CTRL: begin
                    prom_q <= bus_wr_data[CTRL_PROM_BIT];
                    sel_q  <= bus_wr_data[CTRL_BANK_BIT];
                    idx_q  <= bus_wr_data[IDX_W-1:0];
                end
                default: ;
            endcase
        end
    end

    if (FILTER_PRESENT != 0) begin : g_on
        for (genvar p = 0; p < TOTAL; p++) begin : g_ent
            logic hit;
            assign hit = win_we && (phys == PW'(p));
            ffc_entry #(.WORDS(WIN_WORDS)) u_entry (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_data (bus_wr_data),
                .word    (dec.word),
                .val_we  (hit && (dec.kind == RK_VAL)),
                .msk_we  (hit && (dec.kind == RK_MSK)),
                .en_we   (hit && (dec.kind == RK_ENA)),
                .value_o (val_all[p*EBITS +: EBITS]),
                .mask_o  (msk_all[p*EBITS +: EBITS]),
                .en_o    (en_all[p])
            );
        end
    end else begin : g_off
        assign val_all = '0;
        assign msk_all = '0;
        assign en_all  = '0;
    end

    always_comb begin
        mux_word = '0;
        unique case (dec.kind)
            RK_UC_LO: mux_word = uc_lo_q;
            RK_UC_HI: mux_word = {16'h0, uc_hi_q};
            RK_CTRL:  mux_word = {prom_q, 22'h0, sel_q, 4'h0, idx_q};
            RK_ENA:   mux_word = {31'h0, legal && en_all[phys]};
            RK_VAL:   if (legal) mux_word = val_all[int'(phys)*EBITS + int'(dec.word)*DATA_W +: DATA_W];
            RK_MSK:   if (legal) mux_word = msk_all[int'(phys)*EBITS + int'(dec.word)*DATA_W +: DATA_W];
            default:  mux_word = '0;
        endcase
    end

    assign rd_word = (FILTER_PRESENT != 0) ? mux_word : '0;

    ffc_rd_fsm u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (bus_rd_en),
        .rd_word (rd_word),
        .rd_data (bus_rd_data)
    );

    assign unicast_addr = (FILTER_PRESENT != 0) ? {uc_hi_q, uc_lo_q} : 48'h0;
    assign promisc_en   = (FILTER_PRESENT != 0) ? prom_q : 1'b1;
    assign flt_value    = val_all;
    assign flt_mask     = msk_all;
    assign flt_enable   = en_all;
endmodule

// File: rtl/ffc_filter_bank_chk.sv
module ffc_filter_bank_chk
    import ffc_pkg::*;
#(
    parameter int NUM_GEN = 16,
    parameter int NUM_DED = 3,
    parameter int TOTAL   = 19,
    parameter int EBITS   = 512
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_wr_en,
    input logic [DATA_W-1:0]      bus_wr_data,
    input logic                   bus_rd_en,
    input logic [DATA_W-1:0]      bus_rd_data,
    input logic [47:0]            unicast_addr,
    input logic                   promisc_en,
    input logic [TOTAL*EBITS-1:0] flt_value,
    input logic [TOTAL*EBITS-1:0] flt_mask,
    input logic [TOTAL-1:0]       flt_enable,
    input logic                   sel_q,
    input logic [IDX_W-1:0]       idx_q
);
    localparam logic [IDX_W:0] DED_LIM = (IDX_W+1)'(NUM_DED);
    int  chk_phys;
    logic chk_legal, chk_decoded;

    assign chk_phys    = sel_q ? NUM_GEN + int'(idx_q) : int'(idx_q);
    assign chk_legal   = !(sel_q && ({1'b0, idx_q} >= DED_LIM));
    assign chk_decoded = (bus_addr[1:0] == 2'b00) && (bus_addr >= OFS_UC_LO) && (bus_addr < OFS_END);

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !bus_rd_en |=> bus_rd_data == '0); // R8
    AST_UCAST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr_en && bus_addr == OFS_UC_LO) |=> unicast_addr[31:0] == $past(bus_wr_data)); // R2
    AST_UCAST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr_en && bus_addr == OFS_UC_HI) |=> unicast_addr[47:32] == $past(bus_wr_data[15:0])); // R2
    AST_PROMISC_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr_en && bus_addr == OFS_CTRL) |=> promisc_en == $past(bus_wr_data[CTRL_PROM_BIT])); // R3
    AST_DED_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr_en && !chk_legal) |=> ($stable(flt_value) && $stable(flt_mask) && $stable(flt_enable))); // R6
    AST_UNDECODED_READ: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd_en && !chk_decoded) |=> bus_rd_data == '0); // R7
    AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr_en && chk_legal && bus_addr == OFS_ENA) |=> flt_enable[$past(chk_phys)] == $past(bus_wr_data[0])); // R5
endmodule

bind ffc_filter_bank ffc_filter_bank_chk #(
    .NUM_GEN (NUM_GEN),
    .NUM_DED (NUM_DED),
    .TOTAL   (TOTAL),
    .EBITS   (EBITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr_en    (bus_wr_en),
    .bus_wr_data  (bus_wr_data),
    .bus_rd_en    (bus_rd_en),
    .bus_rd_data  (bus_rd_data),
    .unicast_addr (unicast_addr),
    .promisc_en   (promisc_en),
    .flt_value    (flt_value),
    .flt_mask     (flt_mask),
    .flt_enable   (flt_enable),
    .sel_q        (sel_q),
    .idx_q        (idx_q)
);

// File: tb/ffc_filter_bank_tb.sv
module ffc_filter_bank_tb;
    localparam int NG = 16, ND = 3, TOT = 19, EB = 512;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic bus_wr_en = 1'b0, bus_rd_en = 1'b0;
    logic [31:0] bus_wr_data = '0;
    logic [31:0] bus_rd_data;
    logic [47:0] unicast_addr;
    logic promisc_en;
    logic [TOT*EB-1:0] flt_value, flt_mask;
    logic [TOT-1:0] flt_enable;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_val [TOT][16];
    logic [31:0] m_msk [TOT][16];
    logic        m_en  [TOT];
    logic [31:0] m_uc_lo;
    logic [15:0] m_uc_hi;
    logic        m_prom, m_sel;
    logic [3:0]  m_idx;

    ffc_filter_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
        .unicast_addr(unicast_addr), .promisc_en(promisc_en), .flt_value(flt_value),
        .flt_mask(flt_mask), .flt_enable(flt_enable)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int m_phys();
        return m_sel ? NG + int'(m_idx) : int'(m_idx);
    endfunction

    function automatic bit m_legal();
        return m_sel ? (int'(m_idx) < ND) : 1'b1;
    endfunction

    task automatic model_reset();
        for (int p = 0; p < TOT; p++) begin
            for (int w = 0; w < 16; w++) begin
                m_val[p][w] = (w == 0) ? 32'hFFFF_FFFF : (w == 1) ? 32'h0000_FFFF : 32'h0;
                m_msk[p][w] = m_val[p][w];
            end
            m_en[p] = 1'b1;
        end
        m_uc_lo = '0; m_uc_hi = '0; m_prom = 1'b1; m_sel = 1'b0; m_idx = '0;
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int w;
        if (a[1:0] != 2'b00 || a < 12'h700 || a >= 12'h790) return 32'h0;
        if (a == 12'h700) return m_uc_lo;
        if (a == 12'h704) return {16'h0, m_uc_hi};
        if (a == 12'h708) return {m_prom, 22'h0, m_sel, 4'h0, m_idx};
        if (!m_legal()) return 32'h0;
        if (a == 12'h70C) return {31'h0, m_en[m_phys()]};
        if (a < 12'h750) begin
            w = (int'(a) - 'h710) / 4;
            return m_val[m_phys()][w];
        end
        w = (int'(a) - 'h750) / 4;
        return m_msk[m_phys()][w];
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        if (a[1:0] != 2'b00) return;
        if (a == 12'h700) m_uc_lo = d;
        else if (a == 12'h704) m_uc_hi = d[15:0];
        else if (a == 12'h708) begin m_prom = d[31]; m_sel = d[8]; m_idx = d[3:0]; end
        else if (m_legal()) begin
            if (a == 12'h70C) m_en[m_phys()] = d[0];
            else if (a >= 12'h710 && a < 12'h750) m_val[m_phys()][(int'(a) - 'h710) / 4] = d;
            else if (a >= 12'h750 && a < 12'h790) m_msk[m_phys()][(int'(a) - 'h750) / 4] = d;
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge.
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [11:0] a, input string tag);
        logic [31:0] exp;
        exp = model_read(a);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        check(tag, bus_rd_data, exp);
    endtask

    task automatic check_exports(input string tag);
        int bad_v, bad_m, bad_e;
        bad_v = 0; bad_m = 0; bad_e = 0;
        for (int p = 0; p < TOT; p++) begin
            for (int w = 0; w < 16; w++) begin
                if (flt_value[p*EB + w*32 +: 32] !== m_val[p][w]) bad_v++;
                if (flt_mask[p*EB + w*32 +: 32] !== m_msk[p][w]) bad_m++;
            end
            if (flt_enable[p] !== m_en[p]) bad_e++;
        end
        check({tag, " R4 value export mismatches"}, bad_v, 0);
        check({tag, " R4 mask export mismatches"}, bad_m, 0);
        check({tag, " R5 enable export mismatches"}, bad_e, 0);
        check({tag, " R2 unicast low"}, unicast_addr[31:0], m_uc_lo);
        check({tag, " R2 unicast high"}, {16'h0, unicast_addr[47:32]}, {16'h0, m_uc_hi});
        check({tag, " R3 promisc"}, {31'h0, promisc_en}, {31'h0, m_prom});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int seed_set;
        logic [11:0] a;
        logic [31:0] d;
        seed_set = $urandom(32'h5EED_1234);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R8 idle read data after reset", bus_rd_data, 32'h0);
        bus_read(12'h708, "R1 control reset");
        bus_read(12'h70C, "R1 enable reset");
        bus_read(12'h710, "R1 value word0 reset");
        bus_read(12'h714, "R1 value word1 reset");
        bus_read(12'h718, "R1 value word2 reset");
        bus_read(12'h754, "R1 mask word1 reset");
        bus_read(12'h78C, "R1 mask word15 reset");
        bus_read(12'h700, "R1 unicast low reset");
        check_exports("R1 reset");

        // R8 return to zero after a read
        @(negedge clk);
        check("R8 data zero after idle cycle", bus_rd_data, 32'h0);

        // R2 unicast and byte order
        bus_write(12'h700, 32'hDDCC_BBAA);
        bus_write(12'h704, 32'h1234_FFEE);
        bus_read(12'h704, "R2 reserved upper half reads zero");
        check("R2 unicast byte order low", unicast_addr[31:0], 32'hDDCC_BBAA);
        check("R2 unicast byte order high", {16'h0, unicast_addr[47:32]}, 32'h0000_FFEE);

        // R3 control fields
        bus_write(12'h708, 32'hFFFF_FFFF);
        bus_read(12'h708, "R3 control reserved bits");
        bus_write(12'h708, 32'h0000_0005);
        check("R3 promisc cleared", {31'h0, promisc_en}, 32'h0);

        // R4 and R9: general entry 5 word 3, read back on the next cycle
        bus_write(12'h71C, 32'hA5A5_0001);
        bus_read(12'h71C, "R9 read right after write");
        bus_write(12'h780, 32'h0F0F_0F0F);
        check("R4 entry5 value word3", flt_value[5*EB + 3*32 +: 32], 32'hA5A5_0001);
        check("R4 entry5 mask word12", flt_mask[5*EB + 12*32 +: 32], 32'h0F0F_0F0F);

        // R4/R5 dedicated entry 2 is physical 18
        bus_write(12'h708, 32'h0000_0102);
        bus_write(12'h710, 32'h1111_2222);
        bus_write(12'h70C, 32'h0000_0000);
        check("R4 dedicated entry value", flt_value[18*EB +: 32], 32'h1111_2222);
        check("R5 dedicated enable cleared", {31'h0, flt_enable[18]}, 32'h0);
        bus_read(12'h70C, "R5 enable read");

        // R6 dedicated index 3 locked
        bus_write(12'h708, 32'h0000_0103);
        bus_write(12'h710, 32'hDEAD_BEEF);
        bus_write(12'h750, 32'hDEAD_BEEF);
        bus_write(12'h70C, 32'h0000_0000);
        check_exports("R6 locked writes");
        bus_read(12'h710, "R6 locked value read");
        bus_read(12'h70C, "R6 locked enable read");

        // R7 undecoded reads
        bus_read(12'h790, "R7 past the window");
        bus_read(12'h6FC, "R7 below the range");
        bus_read(12'h702, "R7 misaligned");

        // Constrained random traffic
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom % 10);
            d = $urandom;
            if (r < 2) begin
                d[8] = ($urandom % 4) == 0;
                d[3:0] = d[8] ? 4'($urandom % 5) : 4'($urandom % 16);
                bus_write(12'h708, d);
            end else if (r < 5) begin
                a = 12'(12'h710 + 12'(($urandom % 32) * 4));
                bus_write(a, d);
            end else if (r == 5) begin
                bus_write(12'h70C, d);
            end else if (r == 6) begin
                bus_write(($urandom % 2) ? 12'h700 : 12'h704, d);
            end else begin
                if (($urandom % 4) == 0) a = 12'($urandom);
                else a = 12'(12'h700 + 12'(($urandom % 36) * 4));
                bus_read(a, "R4 random read");
            end
            if ((i % 50) == 49) check_exports("R9 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule